// File: doc/BRIEF.md
# Bidirectional Handshake Bus Port

This block is an 8-bit peripheral port that moves data in both directions over one shared bus. On the processor side, a write stores a byte in the outgoing latch and a read returns the byte held in the incoming latch. On the peripheral side, the bus is a three-state pad. The block supplies the value to drive and a drive enable.

Two active-low handshake inputs control the peripheral side:
- **Acknowledge** makes the port drive the outgoing byte onto the bus. It also marks that byte as taken.
- **Strobe** makes the port capture the bus into the incoming latch.

Two status outputs report the state of the latches. `obf_n` is low while a written byte has not yet been taken. `ibf` is high while a captured byte has not yet been read.

A single active-high interrupt request combines one condition from the output side and one from the input side. Each condition has its own enable bit. Software changes an enable with a single-bit set/reset command: bit number 6 selects the output-side enable and bit number 4 selects the input-side enable.

The handshake inputs and the incoming bus are sampled through a synchronizer of `SYNC_STAGES` flops, so the peripheral may run asynchronously to the port. The bus drive enable follows acknowledge directly, without a flop, so the pad turns around without waiting for the synchronizer.

Top module: `hs_bidir_port`

## Requirements
- R1: After reset, `obf_n` is 1, `ibf` is 0, both interrupt enables are 0 and `intr` is 0.
- R2: A cycle with `cpu_wr` high loads `cpu_wdata` into the outgoing latch. `bus_out` shows that latch from the next cycle on.
- R3: A cycle with `cpu_wr` high drives `obf_n` to 0 on the next cycle. This holds even when a synchronized acknowledge falls in the same cycle: the write wins.
- R4: `bus_oe` is 1 exactly while `ack_n` is 0, with no register in the path. A synchronized low on `ack_n` with no write in the same cycle sets `obf_n` to 1.
- R5: While the synchronized `stb_n` is low, every cycle loads the synchronized `bus_in` into the incoming latch and sets `ibf` to 1. `cpu_rdata` always shows the incoming latch.
- R6: A cycle with `cpu_rd` high clears `ibf`, except when a strobe capture falls in the same cycle. In that case `ibf` stays 1 and the newly captured byte is kept.
- R7: A cycle with `cfg_wr` high and `cfg_bit` equal to 6 sets the output-side enable to `cfg_val`. `cfg_bit` equal to 4 sets the input-side enable to `cfg_val`. Any other `cfg_bit` value leaves both enables unchanged.
- R8: `intr` equals (`obf_n` high AND synchronized acknowledge high AND output-side enable) OR (`ibf` high AND synchronized strobe high AND input-side enable).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Processor write of the outgoing latch |
| cpu_wdata | input | DATA_W | Byte to write |
| cpu_rd | input | 1 | Processor read of the incoming latch (clears `ibf`) |
| cpu_rdata | output | DATA_W | Incoming latch contents |
| cfg_wr | input | 1 | Single-bit set/reset command strobe |
| cfg_bit | input | 3 | Bit number addressed by the command |
| cfg_val | input | 1 | Value written to the addressed bit |
| bus_in | input | DATA_W | Bus value seen at the pad |
| bus_out | output | DATA_W | Value to drive onto the bus |
| bus_oe | output | 1 | Pad drive enable, high while acknowledge is low |
| ack_n | input | 1 | Active-low acknowledge from the peripheral |
| stb_n | input | 1 | Active-low strobe from the peripheral |
| obf_n | output | 1 | Active-low outgoing byte pending |
| ibf | output | 1 | Incoming byte held and not yet read |
| intr | output | 1 | Merged interrupt request, active high |

## Verification
Two pairs of events can land on the same clock edge:
- a processor write and a synchronized acknowledge, which both act on `obf_n`;
- a processor read and a strobe capture, which both act on `ibf`.

Each collision is provoked by holding the handshake line low long enough to pass the synchronizer, then pulsing the processor strobe for exactly one cycle. In the write case, `obf_n` must read 0 one cycle after the write and 1 the cycle after that. In the read case, `ibf` must stay 1 and `cpu_rdata` must still show the held bus value.

// File: rtl/hs_pkg.sv
package hs_pkg;
   // Control-port bit numbers used by the single-bit set/reset command
   localparam logic [2:0] BIT_EN_IN  = 3'd4;
   localparam logic [2:0] BIT_EN_OUT = 3'd6;

   typedef struct packed {
      logic en_out;
      logic en_in;
   } hs_en_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("hs_sync: W must be at least 1");
   end
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("hs_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
         end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
         end
      end
      assign q = chain_q[STAGES-1];
   end
endmodule

// File: rtl/hs_out_path.sv
module hs_out_path #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              ack_s_n,
   output logic [DATA_W-1:0] out_q,
   output logic              obf_n_q
);
   logic obf_n_d;

   always_comb begin
      obf_n_d = obf_n_q;
      if (cpu_wr)        obf_n_d = 1'b0;   // write wins over acknowledge
      else if (!ack_s_n) obf_n_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q   <= '0;
         obf_n_q <= 1'b1;
      end else begin
         if (cpu_wr) out_q <= cpu_wdata;
         obf_n_q <= obf_n_d;
      end
   end

   AST_WR_LOADS:   assert property (@(posedge clk) disable iff (!rst_n)
                      cpu_wr |=> out_q == $past(cpu_wdata));          // R2
   AST_WR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
                      cpu_wr |=> !obf_n_q);                           // R3
   AST_ACK_TAKES:  assert property (@(posedge clk) disable iff (!rst_n)
                      (!ack_s_n && !cpu_wr) |=> obf_n_q);             // R4
   AST_OUT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                      !cpu_wr |=> $stable(out_q));                    // R2
endmodule

// File: rtl/hs_in_path.sv
module hs_in_path #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_rd,
   input  logic              stb_s_n,
   input  logic [DATA_W-1:0] bus_s,
   output logic [DATA_W-1:0] in_q,
   output logic              ibf_q
);
   logic ibf_d;

   always_comb begin
      ibf_d = ibf_q;
      if (!stb_s_n)    ibf_d = 1'b1;   // capture wins over read
      else if (cpu_rd) ibf_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= '0;
         ibf_q <= 1'b0;
      end else begin
         if (!stb_s_n) in_q <= bus_s;
         ibf_q <= ibf_d;
      end
   end

   AST_STB_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
                     !stb_s_n |=> (ibf_q && in_q == $past(bus_s)));   // R5
   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                     (cpu_rd && stb_s_n) |=> !ibf_q);                 // R6
   AST_IBF_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                     (!cpu_rd && ibf_q) |=> ibf_q);                   // R5
endmodule

// File: rtl/hs_intr.sv
module hs_intr
   import hs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_wr,
   input  logic [2:0] cfg_bit,
   input  logic       cfg_val,
   input  logic       obf_n,
   input  logic       ack_s_n,
   input  logic       ibf,
   input  logic       stb_s_n,
   output logic       intr
);
   hs_en_t en_q;
   logic   out_cond;
   logic   in_cond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (cfg_wr) begin
         if (cfg_bit == BIT_EN_OUT) en_q.en_out <= cfg_val;
         if (cfg_bit == BIT_EN_IN)  en_q.en_in  <= cfg_val;
      end
   end

   assign out_cond = obf_n & ack_s_n & en_q.en_out;
   assign in_cond  = ibf & stb_s_n & en_q.en_in;
   assign intr     = out_cond | in_cond;

   AST_INTR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
                         intr |-> (en_q.en_out || en_q.en_in));       // R8
   AST_OTHER_BITS:    assert property (@(posedge clk) disable iff (!rst_n)
                         (cfg_wr && cfg_bit != BIT_EN_OUT && cfg_bit != BIT_EN_IN)
                         |=> $stable(en_q));                          // R7
   AST_NO_INTR_BUSY:  assert property (@(posedge clk) disable iff (!rst_n)
                         (!obf_n && !ibf) |-> !intr);                 // R8
endmodule

// File: rtl/hs_bidir_port.sv
module hs_bidir_port #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_rd,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              cfg_wr,
   input  logic [2:0]        cfg_bit,
   input  logic              cfg_val,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   input  logic              ack_n,
   input  logic              stb_n,
   output logic              obf_n,
   output logic              ibf,
   output logic              intr
);
   localparam int SYNC_W = DATA_W + 2;

   if (DATA_W < 1) begin : g_bad_width
      $error("hs_bidir_port: DATA_W must be at least 1");
   end

   logic [SYNC_W-1:0] raw_in;
   logic [SYNC_W-1:0] sync_out;
   logic              ack_s_n;
   logic              stb_s_n;
   logic [DATA_W-1:0] bus_s;

   // Bus data travels through the same stages as the strobe so both arrive together.
   assign raw_in = {ack_n, stb_n, bus_in};

   hs_sync #(
      .W       (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({2'b11, {DATA_W{1'b0}}})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_out)
   );

   assign ack_s_n = sync_out[SYNC_W-1];
   assign stb_s_n = sync_out[SYNC_W-2];
   assign bus_s   = sync_out[DATA_W-1:0];

   hs_out_path #(.DATA_W(DATA_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_wr    (cpu_wr),
      .cpu_wdata (cpu_wdata),
      .ack_s_n   (ack_s_n),
      .out_q     (bus_out),
      .obf_n_q   (obf_n)
   );

   hs_in_path #(.DATA_W(DATA_W)) u_in (
      .clk     (clk),
      .rst_n   (rst_n),
      .cpu_rd  (cpu_rd),
      .stb_s_n (stb_s_n),
      .bus_s   (bus_s),
      .in_q    (cpu_rdata),
      .ibf_q   (ibf)
   );

   hs_intr u_intr (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_wr  (cfg_wr),
      .cfg_bit (cfg_bit),
      .cfg_val (cfg_val),
      .obf_n   (obf_n),
      .ack_s_n (ack_s_n),
      .ibf     (ibf),
      .stb_s_n (stb_s_n),
      .intr    (intr)
   );

   // Pad drive follows the raw acknowledge so the bus turns around at once.
   assign bus_oe = ~ack_n;

   AST_OE_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
                          bus_oe |-> !ack_n);                         // R4
endmodule

// File: tb/hs_bidir_port_bench.sv
module hs_bidir_port_bench;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_wr = 1'b0, cpu_rd = 1'b0, cfg_wr = 1'b0, cfg_val = 1'b0;
   logic [2:0]    cfg_bit = '0;
   logic [DW-1:0] cpu_wdata = '0, bus_in = '0;
   logic          ack_n = 1'b1, stb_n = 1'b1;
   logic [DW-1:0] cpu_rdata, bus_out;
   logic          bus_oe, obf_n, ibf, intr;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;   // 50 MHz

   hs_bidir_port #(.DATA_W(DW), .SYNC_STAGES(2)) u_hs_bidir_port (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cfg_wr(cfg_wr), .cfg_bit(cfg_bit),
      .cfg_val(cfg_val), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .ack_n(ack_n), .stb_n(stb_n), .obf_n(obf_n), .ibf(ibf), .intr(intr)
   );

   // Vector: {en_out, en_in, out_byte, in_byte}
   localparam logic [17:0] VEC [6] = '{
      {1'b1, 1'b1, 8'hA5, 8'h3C},
      {1'b0, 1'b1, 8'h00, 8'hFF},
      {1'b1, 1'b0, 8'hFF, 8'h00},
      {1'b0, 1'b0, 8'h5A, 8'hC3},
      {1'b1, 1'b1, 8'h81, 8'h7E},
      {1'b0, 1'b1, 8'h12, 8'h34}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input logic [2:0] b, input logic v);
      @(negedge clk); cfg_wr = 1'b1; cfg_bit = b; cfg_val = v;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic cpu_write(input logic [DW-1:0] d);
      @(negedge clk); cpu_wr = 1'b1; cpu_wdata = d;
      @(negedge clk); cpu_wr = 1'b0;
   endtask

   task automatic cpu_read();
      @(negedge clk); cpu_rd = 1'b1;
      @(negedge clk); cpu_rd = 1'b0;
   endtask

   initial begin
      #4_000_000;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait_n(3);
      // R1 reset state
      chk("R1 obf_n", obf_n, 1);
      chk("R1 ibf", ibf, 0);
      chk("R1 intr", intr, 0);
      chk("R4 oe idle", bus_oe, 0);
      rst_n = 1'b1;
      wait_n(2);
      chk("R1 intr after reset", intr, 0);

      // R7: bit 6 enables output side; bits 5 and 7 are ignored
      cfg(3'd6, 1'b1);
      chk("R7 bit6 set", intr, 1);
      cfg(3'd5, 1'b0);
      chk("R7 bit5 ignored", intr, 1);
      cfg(3'd6, 1'b0);
      chk("R7 bit6 clear", intr, 0);
      cfg(3'd7, 1'b1);
      chk("R7 bit7 ignored", intr, 0);

      // Table walk
      for (int i = 0; i < 6; i++) begin
         logic eo, ei;
         logic [DW-1:0] ob, ib;
         {eo, ei, ob, ib} = VEC[i];
         cfg(3'd6, eo);
         cfg(3'd4, ei);
         cpu_write(ob);
         chk("R3 obf low after write", obf_n, 0);
         chk("R2 bus_out", bus_out, ob);
         chk("R8 intr busy", intr, 0);
         @(negedge clk); ack_n = 1'b0;
         #1 chk("R4 oe on ack", bus_oe, 1);
         wait_n(4);
         chk("R4 obf high on ack", obf_n, 1);
         chk("R8 intr during ack", intr, 0);
         ack_n = 1'b1;
         #1 chk("R4 oe off", bus_oe, 0);
         wait_n(4);
         chk("R8 intr out", intr, eo);
         bus_in = ib; stb_n = 1'b0;
         wait_n(4);
         chk("R5 ibf set", ibf, 1);
         chk("R5 rdata", cpu_rdata, ib);
         chk("R8 intr during stb", intr, eo);
         stb_n = 1'b1; bus_in = ~ib;
         wait_n(4);
         chk("R8 intr both", intr, eo | ei);
         chk("R5 latch held", cpu_rdata, ib);
         cpu_read();
         chk("R6 ibf cleared", ibf, 0);
         chk("R8 intr after read", intr, eo);
      end

      // R3 collision: write while synchronized acknowledge is low
      @(negedge clk); ack_n = 1'b0;
      wait_n(4);
      @(negedge clk); cpu_wr = 1'b1; cpu_wdata = 8'h99;
      @(negedge clk); cpu_wr = 1'b0;
      chk("R3 write wins over ack", obf_n, 0);
      chk("R2 collision data", bus_out, 8'h99);
      @(negedge clk);
      chk("R4 ack takes next cycle", obf_n, 1);
      ack_n = 1'b1;
      wait_n(4);

      // R6 collision: read while strobe capture is active
      bus_in = 8'h6D; stb_n = 1'b0;
      wait_n(4);
      cpu_read();
      chk("R6 capture wins over read", ibf, 1);
      chk("R6 data kept", cpu_rdata, 8'h6D);
      stb_n = 1'b1;
      wait_n(4);
      chk("R6 ibf still held", ibf, 1);
      cpu_read();
      chk("R6 later read clears", ibf, 0);

      // R1 reset mid-activity
      cpu_write(8'h11);
      rst_n = 1'b0;
      wait_n(1);
      chk("R1 reset obf", obf_n, 1);
      chk("R1 reset intr", intr, 0);
      rst_n = 1'b1;
      wait_n(2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule